// File: doc/BRIEF.md
# Catastrophic Error Pulse Classifier

This block watches a single active-low error line from a processor. The line carries two severities of failure. A recoverable-fatal error shows up as a low pulse of a fixed length of 16 base clocks. A catastrophic error holds the line low until the platform is reset. The block samples the line on the same base clock that drives it and passes it through a two-flop synchronizer. It then counts how many clocks each low phase lasts and sorts the phase into a severity class.

Each classification sets a sticky status bit. It also latches an event code and the measured width for a management controller to read. The block raises a level interrupt while any status bit is set. A catastrophic hold is reported as soon as the low phase passes a configurable threshold, without waiting for the line to rise again. Low phases that fit neither class are flagged as malformed. One clear strobe wipes the status.

Top module: `cat_err_classifier`

## Requirements
- R1: While rst_ni is low, and after its release before any low phase, fatal_o, cat_o, malf_o and irq_o are 0, evt_code_o is 0 (none) and width_o is 0.
- R2: err_ni is active low and is sampled through a two-flop synchronizer. The width of a low phase is the number of clock edges at which the line was sampled low.
- R3: A low phase of 14 to 18 clocks inclusive, once it ends, sets fatal_o, loads evt_code_o with 1 and loads width_o with the measured width.
- R4: A low phase that lasts longer than CAT_THRESH clocks (default 64) sets cat_o, loads evt_code_o with 2 and loads width_o with CAT_THRESH+1. This happens while the line is still low, exactly CAT_THRESH+3 clock edges after the first edge that samples the line low. Releasing the line after that adds no further event.
- R5: A low phase of 1 to 13 clocks, or of 19 to CAT_THRESH clocks, sets malf_o once it ends, loads evt_code_o with 3 and loads width_o with the measured width.
- R6: Status bits are sticky and accumulate across events. evt_code_o and width_o always describe the most recent event. A high clr_i clears all status bits, the code and the width; an event in the same cycle as clr_i wins and is kept.
- R7: irq_o is high exactly when at least one of fatal_o, cat_o or malf_o is set.
- R8: The width counter saturates at its all-ones value. A held-low phase yields at most one event, even when it outlasts the counter range or is cleared while still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock shared with the error source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_ni | input | 1 | Active-low error line from the processor |
| clr_i | input | 1 | Clear strobe for status, code and width |
| fatal_o | output | 1 | Sticky: recoverable-fatal pulse seen |
| cat_o | output | 1 | Sticky: catastrophic hold seen |
| malf_o | output | 1 | Sticky: malformed low phase seen |
| irq_o | output | 1 | Level interrupt, any status bit set |
| evt_code_o | output | 2 | Last event: 0 none, 1 fatal, 2 catastrophic, 3 malformed |
| width_o | output | CNT_W | Width in clocks of the last event |

## Verification
The bench aims at the edges of the fatal window: 13, 14, 18 and 19 clocks. A design with an off-by-one compare would report a malformed pulse as fatal there, or the reverse. It also checks the catastrophic threshold at 64 and 65 clocks, and the exact edge where cat_o rises while the line is still low. A design that waits for the release, or that counts the synchronizer stages wrongly, misses that edge. Holds longer than the counter range, and clears issued during a hold, are checked for spurious second events; a counter that wraps or re-arms would produce one. A clear strobe that coincides with an event is checked so that the event is not lost.

// File: rtl/cerr_pkg.sv
package cerr_pkg;
  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_FATAL = 2'd1,
    EVT_CAT   = 2'd2,
    EVT_MALF  = 2'd3
  } evt_e;
endpackage

// File: rtl/cerr_sync.sv
module cerr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cerr_width_cnt.sv
module cerr_width_cnt #(
  parameter int CNT_W      = 8,
  parameter int CAT_THRESH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             low_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rel_o,
  output logic             cat_o,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] Thresh = CAT_THRESH[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q;
  logic             cat_done_q;

  // catastrophic decision taken while still low; release afterwards is silent
  assign cat_o   = low_i && !cat_done_q && (cnt_q == Thresh);
  assign rel_o   = !low_i && (cnt_q != '0) && !cat_done_q;
  assign width_o = cat_o ? cnt_q + 1'b1 : cnt_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cat_done_q <= 1'b0;
    end else begin
      if (!low_i)               cnt_q <= '0;
      else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;

      if (!low_i)     cat_done_q <= 1'b0;
      else if (cat_o) cat_done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cerr_classify.sv
module cerr_classify
  import cerr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FATAL_MIN = 14,
  parameter int FATAL_MAX = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rel_i,
  input  logic             cat_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             clr_i,
  output logic             fatal_o,
  output logic             cat_o,
  output logic             malf_o,
  output evt_e             code_o,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] FMin = FATAL_MIN[CNT_W-1:0];
  localparam logic [CNT_W-1:0] FMax = FATAL_MAX[CNT_W-1:0];

  evt_e evt;
  logic in_win;

  assign in_win = (width_i >= FMin) && (width_i <= FMax);

  always_comb begin
    evt = EVT_NONE;
    if (cat_i)      evt = EVT_CAT;
    else if (rel_i) evt = in_win ? EVT_FATAL : EVT_MALF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fatal_o <= 1'b0;
      cat_o   <= 1'b0;
      malf_o  <= 1'b0;
      code_o  <= EVT_NONE;
      width_o <= '0;
    end else begin
      if (clr_i) begin
        fatal_o <= 1'b0;
        cat_o   <= 1'b0;
        malf_o  <= 1'b0;
        code_o  <= EVT_NONE;
        width_o <= '0;
      end
      // a fresh event overrides a simultaneous clear
      if (evt != EVT_NONE) begin
        code_o  <= evt;
        width_o <= width_i;
        unique case (evt)
          EVT_FATAL: fatal_o <= 1'b1;
          EVT_CAT:   cat_o   <= 1'b1;
          EVT_MALF:  malf_o  <= 1'b1;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cat_err_classifier.sv
module cat_err_classifier
  import cerr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int FATAL_MIN   = 14,
  parameter int FATAL_MAX   = 18,
  parameter int CAT_THRESH  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_ni,
  input  logic             clr_i,
  output logic             fatal_o,
  output logic             cat_o,
  output logic             malf_o,
  output logic             irq_o,
  output logic [1:0]       evt_code_o,
  output logic [CNT_W-1:0] width_o
);
  logic             err_s;
  logic             low_s;
  logic [CNT_W-1:0] cnt;
  logic             rel_evt;
  logic             cat_evt;
  logic [CNT_W-1:0] evt_width;
  evt_e             code;

  cerr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (err_ni),
    .q_o   (err_s)
  );

  assign low_s = ~err_s;

  cerr_width_cnt #(.CNT_W(CNT_W), .CAT_THRESH(CAT_THRESH)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .low_i  (low_s),
    .cnt_o  (cnt),
    .rel_o  (rel_evt),
    .cat_o  (cat_evt),
    .width_o(evt_width)
  );

  cerr_classify #(.CNT_W(CNT_W), .FATAL_MIN(FATAL_MIN), .FATAL_MAX(FATAL_MAX)) u_cls (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rel_i  (rel_evt),
    .cat_i  (cat_evt),
    .width_i(evt_width),
    .clr_i  (clr_i),
    .fatal_o(fatal_o),
    .cat_o  (cat_o),
    .malf_o (malf_o),
    .code_o (code),
    .width_o(width_o)
  );

  assign evt_code_o = code;
  assign irq_o      = fatal_o | cat_o | malf_o;
endmodule

// File: rtl/cerr_checker.sv
module cerr_checker #(
  parameter int CNT_W      = 8,
  parameter int FATAL_MIN  = 14,
  parameter int FATAL_MAX  = 18,
  parameter int CAT_THRESH = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             fatal_o,
  input logic             cat_o,
  input logic             malf_o,
  input logic             irq_o,
  input logic [1:0]       evt_code_o,
  input logic [CNT_W-1:0] width_o,
  input logic             low_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CatW   = CNT_W'(CAT_THRESH + 1);
  localparam logic [CNT_W-1:0] FMin   = FATAL_MIN[CNT_W-1:0];
  localparam logic [CNT_W-1:0] FMax   = FATAL_MAX[CNT_W-1:0];

  a_r3_fatal_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fatal_o) |-> (width_o >= FMin && width_o <= FMax));

  a_r4_cat_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cat_o) |-> (width_o == CatW && evt_code_o == 2'd2));

  a_r5_malf_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(malf_o) |-> (width_o < FMin || width_o > FMax));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fatal_o || cat_o || malf_o) && !clr_i |=> (fatal_o || cat_o || malf_o));

  a_r7_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (evt_code_o == 2'd0 && width_o == '0));

  a_r8_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CntMax && low_i) |=> (cnt_i == CntMax));
endmodule

bind cat_err_classifier cerr_checker #(
  .CNT_W(CNT_W), .FATAL_MIN(FATAL_MIN), .FATAL_MAX(FATAL_MAX), .CAT_THRESH(CAT_THRESH)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .fatal_o   (fatal_o),
  .cat_o     (cat_o),
  .malf_o    (malf_o),
  .irq_o     (irq_o),
  .evt_code_o(evt_code_o),
  .width_o   (width_o),
  .low_i     (low_s),
  .cnt_i     (cnt)
);

// File: tb/sim_cat_err_classifier.sv
module sim_cat_err_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int THRESH     = 64;

  logic             clk = 1'b0;
  logic             rst_ni, err_ni, clr_i;
  logic             fatal_o, cat_o, malf_o, irq_o;
  logic [1:0]       evt_code_o;
  logic [CNT_W-1:0] width_o;

  int n_run = 0, n_fail = 0;
  bit m_fatal, m_cat, m_malf;
  int m_code, m_width;

  always #(CLK_PERIOD/2) clk = ~clk;

  cat_err_classifier u0 (
    .clk_i(clk), .rst_ni(rst_ni), .err_ni(err_ni), .clr_i(clr_i),
    .fatal_o(fatal_o), .cat_o(cat_o), .malf_o(malf_o), .irq_o(irq_o),
    .evt_code_o(evt_code_o), .width_o(width_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input int n);
    if (n > THRESH) return 2;
    if (n >= 14 && n <= 18) return 1;
    return 3;
  endfunction

  function automatic int exp_width(input int n);
    return (n > THRESH) ? THRESH + 1 : n;
  endfunction

  task automatic model_event(input int n);
    m_code  = exp_code(n);
    m_width = exp_width(n);
    case (m_code)
      1: m_fatal = 1'b1;
      2: m_cat   = 1'b1;
      default: m_malf = 1'b1;
    endcase
  endtask

  task automatic model_clear();
    m_fatal = 0; m_cat = 0; m_malf = 0; m_code = 0; m_width = 0;
  endtask

  task automatic check_all(input string tag);
    check({tag, " fatal_o"}, fatal_o, m_fatal);
    check({tag, " cat_o"}, cat_o, m_cat);
    check({tag, " malf_o"}, malf_o, m_malf);
    check({tag, " code"}, evt_code_o, m_code);
    check({tag, " width"}, width_o, m_width);
    check("R7 irq_o", irq_o, int'(m_fatal | m_cat | m_malf));
  endtask

  task automatic pulse(input int n, input string tag);
    err_ni = 1'b0;
    repeat (n) @(negedge clk);
    err_ni = 1'b1;
    repeat (6) @(negedge clk);
    model_event(n);
    check_all(tag);
  endtask

  task automatic do_clear();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_ni = 1'b0; err_ni = 1'b1; clr_i = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after reset");

    // R3 window edges, R2 width counting
    pulse(14, "R3 n=14");
    pulse(18, "R3 n=18");
    do_clear();
    check_all("R6 clear");
    // R5 just outside window
    pulse(13, "R5 n=13");
    pulse(19, "R5 n=19");
    pulse(1, "R5 n=1");
    pulse(THRESH, "R5 n=thresh");
    // R6 accumulate: fatal on top of malformed
    pulse(16, "R6 accumulate");
    do_clear();

    // R4 latency: not yet after THRESH+2 edges, set after THRESH+3
    err_ni = 1'b0;
    repeat (THRESH + 2) @(negedge clk);
    check("R4 cat_o before threshold", cat_o, 0);
    @(negedge clk);
    check("R4 cat_o while still low", cat_o, 1);
    check("R4 code", evt_code_o, 2);
    check("R4 width", width_o, THRESH + 1);
    repeat (30) @(negedge clk);
    err_ni = 1'b1;
    repeat (6) @(negedge clk);
    model_event(THRESH + 1);
    check_all("R4 release silent");
    pulse(THRESH + 1, "R4 n=thresh+1");
    do_clear();

    // R6 clear coincident with release event
    err_ni = 1'b0;
    repeat (15) @(negedge clk);
    err_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    repeat (4) @(negedge clk);
    model_event(15);
    check_all("R6 event beats clear");
    do_clear();

    // R8 long hold beyond counter range, cleared mid-hold
    err_ni = 1'b0;
    repeat (100) @(negedge clk);
    check("R8 cat during hold", cat_o, 1);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    repeat (250) @(negedge clk);
    check("R8 no re-report during hold", irq_o, 0);
    err_ni = 1'b1;
    repeat (6) @(negedge clk);
    model_clear();
    check_all("R8 release after saturation");

    // random mix
    for (int i = 0; i < 40; i++) begin
      int sel, n;
      sel = $urandom_range(0, 3);
      case (sel)
        0: n = $urandom_range(1, 13);
        1: n = $urandom_range(14, 18);
        2: n = $urandom_range(19, THRESH);
        default: n = $urandom_range(THRESH + 1, THRESH + 30);
      endcase
      pulse(n, "R2 random");
      if ($urandom_range(0, 4) == 0) begin
        do_clear();
        check_all("R6 random clear");
      end
      repeat ($urandom_range(0, 4)) @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule